// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer execute stage of a load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit constant shift amount and a 5-bit operation code. It computes one of seventeen operations:

- add and subtract, each in a trapping and a non-trapping form;
- the four bitwise operations;
- signed and unsigned set-less-than;
- upper-immediate placement;
- logical and arithmetic shifts, by a constant or by a register amount.

The result, an overflow flag and a register-write enable are captured in one output register. The result appears on the outputs one clock after the inputs are presented.

When a trapping add or subtract overflows, the result is still driven. The write enable drops so that the core can discard the write and take its exception. Decoding instructions into the operation code, extending immediates, reading the register file and handling the exception all take place outside this block.

Top module: `alu_exec`

## Requirements
- R1: While rst_n is low, result_o, ovf_o and wr_en_o are all 0.
- R2: Outputs change only at a rising clock edge. They reflect the op_i, a_i, b_i and shamt_i values present at that edge, so the latency is one cycle.
- R3: Op 0 (trapping add, A+B) and op 2 (trapping subtract, A-B) drive the 32-bit wrapped result. They set ovf_o when the two's-complement result does not fit in 32 bits.
- R4: Op 1 (non-trapping add) and op 3 (non-trapping subtract) produce the same 32-bit result as ops 0 and 2, and ovf_o is always 0.
- R5: For every operation, wr_en_o is the inverse of ovf_o.
- R6: The bitwise ops produce the following results: op 4 gives A AND B, op 5 gives A OR B, op 6 gives A XOR B, and op 7 gives NOT(A OR B).
- R7: Op 8 returns 1 when A < B as signed numbers and 0 otherwise. Op 9 does the same comparison on unsigned numbers. Bits 31:1 of both results are 0. For example, A=all ones and B=1 give 1 for op 8 and 0 for op 9.
- R8: Op 10 places B[15:0] in result bits 31:16 and zeros in bits 15:0.
- R9: Ops 11, 12 and 13 shift A by shamt_i. Op 11 is a logical left shift, op 12 a logical right shift and op 13 an arithmetic right shift.
- R10: Ops 14, 15 and 16 shift A in the same three ways, by the amount in B[4:0]. Bits 31:5 of B have no effect on these ops.
- R11: Arithmetic right shifts fill vacated high bits with A[31]. Logical shifts fill vacated bits with zeros.
- R12: Op codes 17 to 31 give a result of 0 and ovf_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (also immediate and variable shift amount) |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered overflow exception flag |
| wr_en_o | output | 1 | Registered register-write enable |

## Verification
Every output of this block is due exactly one rising edge after its stimulus.

The bench drives inputs on a falling edge and samples on the next falling edge, so exactly one capture edge separates stimulus from check. One case also samples just after the inputs change, before the edge, to confirm that the previous result is still held.

Expected results, flags and enables come from plain arithmetic in the bench. The bench sweeps every op code over a grid of boundary operands and rotating shift amounts. It also runs full shift-amount sweeps.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int XLEN  = 32;
    localparam int SHW   = $clog2(XLEN);
    localparam int IMM_W = 16;
    localparam int OP_W  = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_LUI  = 5'd10,
        OP_SLL  = 5'd11,
        OP_SRL  = 5'd12,
        OP_SRA  = 5'd13,
        OP_SLLV = 5'd14,
        OP_SRLV = 5'd15,
        OP_SRAV = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            ovf;
        logic            wr_en;
    } alu_out_s;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   res
);
    logic [W-1:0] stage [0:SHW];
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic         fill;

    assign fill = arith & ~left & val[W-1];

    for (genvar k = 0; k < W; k++) begin : g_rev
        assign rev_in[k]  = val[W-1-k];
        assign rev_out[k] = stage[SHW][W-1-k];
    end

    assign stage[0] = left ? rev_in : val;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]} : stage[i];
    end

    assign res = left ? rev_out : stage[SHW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] xor_r,
    output logic [W-1:0] nor_r,
    output logic         lt_s,
    output logic         lt_u
);
    always_comb begin
        and_r = a & b;
        or_r  = a | b;
        xor_r = a ^ b;
        nor_r = ~(a | b);
        lt_s  = $signed(a) < $signed(b);
        lt_u  = a < b;
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [SHW-1:0]  shamt_i,
    output logic [XLEN-1:0] result_o,
    output logic            ovf_o,
    output logic            wr_en_o
);
    alu_op_e  op;
    alu_out_s out_d, out_q;

    logic [XLEN-1:0] sum_w, and_w, or_w, xor_w, nor_w, shf_w;
    logic            ovf_w, lts_w, ltu_w;
    logic            is_sub, is_var, is_left, is_arith;
    logic [SHW-1:0]  amt_w;

    assign op       = alu_op_e'(op_i);
    assign is_sub   = (op == OP_SUB) || (op == OP_SUBU);
    assign is_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    assign is_left  = (op == OP_SLL) || (op == OP_SLLV);
    assign is_arith = (op == OP_SRA) || (op == OP_SRAV);
    assign amt_w    = is_var ? b_i[SHW-1:0] : shamt_i;

    alu_addsub #(.W(XLEN)) u_addsub (
        .a(a_i), .b(b_i), .sub(is_sub), .sum(sum_w), .ovf(ovf_w)
    );

    alu_shift #(.W(XLEN), .SHW(SHW)) u_shift (
        .val(a_i), .amt(amt_w), .left(is_left), .arith(is_arith), .res(shf_w)
    );

    alu_logic #(.W(XLEN)) u_logic (
        .a(a_i), .b(b_i), .and_r(and_w), .or_r(or_w), .xor_r(xor_w),
        .nor_r(nor_w), .lt_s(lts_w), .lt_u(ltu_w)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                out_d.result = sum_w;
                out_d.ovf    = ovf_w;
            end
            OP_ADDU, OP_SUBU: out_d.result = sum_w;
            OP_AND:  out_d.result = and_w;
            OP_OR:   out_d.result = or_w;
            OP_XOR:  out_d.result = xor_w;
            OP_NOR:  out_d.result = nor_w;
            OP_SLT:  out_d.result = {{(XLEN-1){1'b0}}, lts_w};
            OP_SLTU: out_d.result = {{(XLEN-1){1'b0}}, ltu_w};
            OP_LUI:  out_d.result = {b_i[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: out_d.result = shf_w;
            default: out_d.result = '0;
        endcase
        out_d.wr_en = ~out_d.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.result;
    assign ovf_o    = out_q.ovf;
    assign wr_en_o  = out_q.wr_en;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!rst_n |-> (result_o == '0 && !ovf_o && !wr_en_o))); // R1
    AST_NO_TRAP_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADDU || op_i == OP_SUBU) |=> !ovf_o); // R4
    AST_WE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) ovf_o |-> !wr_en_o); // R5
    AST_NOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOR) |=> result_o == ~($past(a_i) | $past(b_i))); // R6
    AST_SLT_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SLT || op_i == OP_SLTU) |=> result_o[XLEN-1:1] == '0); // R7
    AST_LUI_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LUI) |=> (result_o[IMM_W-1:0] == '0 &&
                              result_o[XLEN-1:XLEN-IMM_W] == $past(b_i[IMM_W-1:0]))); // R8
    AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SRA || op_i == OP_SRAV) && a_i[XLEN-1]) |=> result_o[XLEN-1]); // R11
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_SRAV) |=> (result_o == '0 && !ovf_o)); // R12
endmodule

// File: tb/sim_alu_exec.sv
module sim_alu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;
    logic        wr_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu_exec u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o), .wr_en_o(wr_en_o)
    );

    function automatic string req_of(int op);
        case (op)
            0, 2:         return "R3";
            1, 3:         return "R4";
            4, 5, 6, 7:   return "R6";
            8, 9:         return "R7";
            10:           return "R8";
            11, 12:       return "R9";
            13, 16:       return "R11";
            14, 15:       return "R10";
            default:      return "R12";
        endcase
    endfunction

    function automatic logic [32:0] model(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        logic [31:0] r;
        logic        v;
        logic signed [31:0] sa;
        sa = a;
        r = '0;
        v = 1'b0;
        case (op)
            0: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
            1: r = a + b;
            2: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
            3: r = a - b;
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = ~(a | b);
            8: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            9: r = (a < b) ? 32'd1 : 32'd0;
            10: r = {b[15:0], 16'h0000};
            11: r = a << sh;
            12: r = a >> sh;
            13: r = 32'(sa >>> sh);
            14: r = a << b[4:0];
            15: r = a >> b[4:0];
            16: r = 32'(sa >>> b[4:0]);
            default: r = '0;
        endcase
        return {v, r};
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic run(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        logic [32:0] e;
        @(negedge clk);
        op_i = 5'(op); a_i = a; b_i = b; shamt_i = sh;
        e = model(op, a, b, sh);
        @(negedge clk);
        check(req_of(op), $sformatf("result op=%0d a=%h b=%h sh=%0d", op, a, b, sh), result_o, e[31:0]);
        check((op == 1 || op == 3) ? "R4" : "R3", $sformatf("ovf op=%0d a=%h b=%h", op, a, b),
              {31'b0, ovf_o}, {31'b0, e[32]});
        check("R5", $sformatf("wr_en op=%0d", op), {31'b0, wr_en_o}, {31'b0, ~e[32]});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    logic [31:0] vals [14] = '{32'h0, 32'h1, 32'h2, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
                               32'h80000001, 32'h12345678, 32'hFFFF0000, 32'h0000FFFF,
                               32'hA5A5A5A5, 32'h7FFFFFFE, 32'h0000003F, 32'hC0000025};

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        op_i = 5'd0; a_i = 32'h7FFFFFFF; b_i = 32'h1;
        repeat (3) @(negedge clk);
        // R1: held in reset with live inputs
        check("R1", "reset result", result_o, 32'h0);
        check("R1", "reset ovf", {31'b0, ovf_o}, 32'h0);
        check("R1", "reset wr_en", {31'b0, wr_en_o}, 32'h0);
        rst_n = 1'b1;

        // R3/R7 named corners
        run(0, 32'h7FFFFFFF, 32'h1, 5'd0);
        run(2, 32'h80000000, 32'h1, 5'd0);
        run(8, 32'hFFFFFFFF, 32'h1, 5'd0);
        run(9, 32'hFFFFFFFF, 32'h1, 5'd0);
        run(8, 32'h2, 32'h1, 5'd0);
        run(9, 32'h2, 32'h1, 5'd0);

        // R2: output holds until the next rising edge
        run(4, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0);
        @(negedge clk);
        op_i = 5'd5; a_i = 32'h0000000F; b_i = 32'h000000F0;
        #1;
        check("R2", "held before edge", result_o, 32'hF000F000);
        @(negedge clk);
        check("R2", "updated after edge", result_o, 32'h000000FF);

        // near-exhaustive grid over all op codes
        for (int op = 0; op < 32; op++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    run(op, vals[i], vals[j], 5'((i * 7 + j + op) % 32));

        // R9/R10/R11: full amount sweeps
        for (int s = 0; s < 32; s++) begin
            run(11, 32'h80000001, 32'h0, 5'(s));
            run(12, 32'h80000001, 32'h0, 5'(s));
            run(13, 32'h80000001, 32'h0, 5'(s));
            run(14, 32'hC0000003, 32'hFFFFFFE0 | 32'(s), 5'd0);
            run(15, 32'hC0000003, 32'hFFFFFFE0 | 32'(s), 5'd0);
            run(16, 32'hC0000003, 32'hFFFFFFE0 | 32'(s), 5'd0);
        end

        summary();
    end
endmodule